// File: doc/BRIEF.md
# Segmented Memory Window Decoder

This block sits on the host side of a bridge. It decides, for every host request, whether the bridge should claim it and pass it downstream as a memory cycle. The region it can claim is the top 256 MB of a 32-bit address space. That region is split into 32 fixed slices of 8 MB each. A 32-bit enable bitmap switches each slice on or off on its own, so there is no base/limit pair to program. The bitmap resets to all zeros, which means no memory address is decoded until software writes it.

A claimed memory request leaves the block one cycle after it arrives. Its address is unchanged, and the block reports the 5-bit index of the slice that matched. Requests marked as I/O port space are claimed whatever the bitmap holds, so the bitmap only steers memory decoding. Software writes and reads the bitmap through a small register port at a parameterised offset.

Top module: `mmio_win_decoder`

## Requirements
- R1: After reset the enable bitmap is zero. A read of it returns 0, `dec_valid` is low, and a memory request to any address in the top region is not claimed.
- R2: A memory request (`req_io`=0) is claimed (`dec_claim`=1) when address bits 31:28 equal 0xF and the bitmap bit selected by address bits 27:23 is set. The result appears with `dec_valid`=1 on the cycle after the request is sampled.
- R3: A memory request whose address bits 31:28 differ from 0xF is never claimed, even with all 32 enable bits set.
- R4: `dec_addr` equals the request address unchanged. When a memory request is claimed, `dec_win` equals address bits 27:23. Otherwise `dec_win` is 0.
- R5: A memory request into the top region whose slice bit is clear is not claimed.
- R6: When bits i and i+1 are both set, the last byte of slice i and the first byte of slice i+1 are both claimed, so the two slices form one contiguous range.
- R7: An I/O port request (`req_io`=1) is always claimed with `dec_io`=1 and `dec_win`=0, whatever its address and whatever the bitmap holds.
- R8: A write with `cfg_addr` equal to ENA_OFS (default 4) loads all 32 bits of the bitmap. A read at that offset returns the bitmap on `cfg_rdata` one cycle later. A read at any other offset returns 0, and a write at any other offset leaves the bitmap unchanged.
- R9: A request sampled in the same cycle as a bitmap write is decoded with the old bitmap. The next request uses the new bitmap.
- R10: In a cycle with no request, the next cycle shows `dec_valid`=0, `dec_claim`=0 and `dec_io`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_rd |
| req_valid | input | 1 | Host request present |
| req_addr | input | 32 | Host request address |
| req_io | input | 1 | 1 = I/O port space, 0 = memory space |
| dec_valid | output | 1 | Decoded result present |
| dec_claim | output | 1 | Bridge claims the request |
| dec_io | output | 1 | Claimed request is I/O port space |
| dec_win | output | 5 | Index of the matched slice |
| dec_addr | output | 32 | Forwarded address |

## Verification
The only state is the enable bitmap. If it is wrong, the block claims a slice it should ignore, or ignores one it should claim. That shows up at `dec_claim` on the cycle after the first request that lands in that slice, and on `cfg_rdata` one cycle after a read. A wrong decode path shows up the same way, as a wrong claim or a wrong `dec_win` on the next cycle. Most bench addresses are aimed inside the top region, with bitmaps that change often, including writes in the same cycle as a request. Each slice bit therefore meets requests both before and after it changes.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    // Address space a host request belongs to
    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    // Pull the slice index out of an address
    function automatic logic [7:0] slice_of(input logic [63:0] addr, input int unsigned shift);
        return 8'(addr >> shift);
    endfunction

endpackage

// File: rtl/win_en_regs.sv
module win_en_regs #(
    parameter int unsigned NWIN    = 32,
    parameter int unsigned CFG_AW  = 4,
    parameter int unsigned ENA_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [NWIN-1:0]   cfg_wdata,
    output logic [NWIN-1:0]   cfg_rdata,
    output logic [NWIN-1:0]   ena
);

    typedef struct packed {
        logic [NWIN-1:0] ena;
        logic [NWIN-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_ena;

    assign sel_ena = (cfg_addr == CFG_AW'(ENA_OFS));

    always_comb begin
        r_d = r_q;
        // read returns the value held before any write in the same cycle
        if (cfg_rd) begin
            r_d.rdata = sel_ena ? r_q.ena : '0;
        end
        if (cfg_wr && sel_ena) begin
            r_d.ena = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata = r_q.rdata;
    assign ena       = r_q.ena;

endmodule

// File: rtl/win_hit_decode.sv
module win_hit_decode
    import win_dec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WIN_SHIFT  = 23,
    parameter int unsigned NWIN       = 32,
    parameter int unsigned REGION_TAG = 15
) (
    input  logic [ADDR_W-1:0]        addr,
    input  space_e                   space,
    input  logic [NWIN-1:0]          ena,
    output logic                     claim,
    output logic                     is_io,
    output logic [$clog2(NWIN)-1:0]  win
);

    localparam int unsigned IDX_W   = $clog2(NWIN);
    localparam int unsigned TAG_LSB = WIN_SHIFT + IDX_W;
    localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;

    logic [IDX_W-1:0] idx;
    logic             tag_ok;
    logic [NWIN-1:0]  sel;
    logic             mem_hit;
    logic [IDX_W-1:0] enc;

    assign idx    = addr[TAG_LSB-1:WIN_SHIFT];
    assign tag_ok = (addr[ADDR_W-1:TAG_LSB] == TAG_W'(REGION_TAG));

    // one comparator per slice
    for (genvar i = 0; i < NWIN; i++) begin : g_slice
        assign sel[i] = tag_ok && (idx == IDX_W'(i)) && ena[i];
    end

    // sel is one-hot or zero, so an OR of indices is the encoder
    always_comb begin
        enc = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (sel[i]) begin
                enc = enc | IDX_W'(i);
            end
        end
    end

    assign mem_hit = (space == SPACE_MEM) && (|sel);
    assign is_io   = (space == SPACE_IO);
    assign claim   = mem_hit || is_io;
    assign win     = mem_hit ? enc : '0;

endmodule

// File: rtl/mmio_win_decoder.sv
module mmio_win_decoder
    import win_dec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WIN_SHIFT  = 23,
    parameter int unsigned NWIN       = 32,
    parameter int unsigned REGION_TAG = 15,
    parameter int unsigned CFG_AW     = 4,
    parameter int unsigned ENA_OFS    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    cfg_rd,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [NWIN-1:0]         cfg_wdata,
    output logic [NWIN-1:0]         cfg_rdata,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_io,
    output logic                    dec_valid,
    output logic                    dec_claim,
    output logic                    dec_io,
    output logic [$clog2(NWIN)-1:0] dec_win,
    output logic [ADDR_W-1:0]       dec_addr
);

    localparam int unsigned IDX_W = $clog2(NWIN);

    typedef struct packed {
        logic              vld;
        logic              claim;
        logic              io;
        logic [IDX_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t             o_d, o_q;
    logic [NWIN-1:0]  ena_w;
    logic             hit_claim;
    logic             hit_io;
    logic [IDX_W-1:0] hit_win;
    space_e           space;

    assign space = req_io ? SPACE_IO : SPACE_MEM;

    win_en_regs #(
        .NWIN    (NWIN),
        .CFG_AW  (CFG_AW),
        .ENA_OFS (ENA_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ena       (ena_w)
    );

    win_hit_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_SHIFT  (WIN_SHIFT),
        .NWIN       (NWIN),
        .REGION_TAG (REGION_TAG)
    ) u_hit (
        .addr  (req_addr),
        .space (space),
        .ena   (ena_w),
        .claim (hit_claim),
        .is_io (hit_io),
        .win   (hit_win)
    );

    always_comb begin
        o_d       = o_q;
        o_d.vld   = req_valid;
        o_d.claim = 1'b0;
        o_d.io    = 1'b0;
        o_d.win   = '0;
        if (req_valid) begin
            o_d.claim = hit_claim;
            o_d.io    = hit_io;
            o_d.win   = hit_win;
            o_d.addr  = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dec_valid = o_q.vld;
    assign dec_claim = o_q.claim;
    assign dec_io    = o_q.io;
    assign dec_win   = o_q.win;
    assign dec_addr  = o_q.addr;

endmodule

// File: rtl/mmio_win_decoder_chk.sv
module mmio_win_decoder_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_SHIFT = 23,
    parameter int unsigned NWIN      = 32,
    parameter int unsigned CFG_AW    = 4,
    parameter int unsigned ENA_OFS   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_rd,
    input logic [CFG_AW-1:0]       cfg_addr,
    input logic [NWIN-1:0]         cfg_rdata,
    input logic                    req_valid,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    req_io,
    input logic                    dec_valid,
    input logic                    dec_claim,
    input logic                    dec_io,
    input logic [$clog2(NWIN)-1:0] dec_win,
    input logic [ADDR_W-1:0]       dec_addr,
    input logic [NWIN-1:0]         ena
);

    localparam int unsigned IDX_W   = $clog2(NWIN);
    localparam int unsigned TAG_LSB = WIN_SHIFT + IDX_W;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dec_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!dec_valid && !dec_claim && !dec_io)); // R10

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (dec_addr == $past(req_addr))); // R4

    AST_TOP_REGION_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_claim && !dec_io) |-> (&dec_addr[ADDR_W-1:TAG_LSB])); // R3

    AST_WIN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_claim && !dec_io) |-> (dec_win == dec_addr[TAG_LSB-1:WIN_SHIFT])); // R4

    AST_ENABLE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io && !ena[req_addr[TAG_LSB-1:WIN_SHIFT]]) |=> !dec_claim); // R5

    AST_IO_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_io) |=> (dec_claim && dec_io && dec_win == '0)); // R7

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == CFG_AW'(ENA_OFS)) |=> (cfg_rdata == $past(ena))); // R8

endmodule

bind mmio_win_decoder mmio_win_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_SHIFT (WIN_SHIFT),
    .NWIN      (NWIN),
    .CFG_AW    (CFG_AW),
    .ENA_OFS   (ENA_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_io    (req_io),
    .dec_valid (dec_valid),
    .dec_claim (dec_claim),
    .dec_io    (dec_io),
    .dec_win   (dec_win),
    .dec_addr  (dec_addr),
    .ena       (ena_w)
);

// File: tb/mmio_win_decoder_bench.sv
`timescale 1ns/1ps
module mmio_win_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        dec_valid;
    logic        dec_claim;
    logic        dec_io;
    logic [4:0]  dec_win;
    logic [31:0] dec_addr;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    logic [31:0] model_en = '0;
    bit          done = 1'b0;

    localparam logic [3:0] OFS = 4'd4;

    always #4 clk = ~clk;

    mmio_win_decoder u_mmio_win_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_io    (req_io),
        .dec_valid (dec_valid),
        .dec_claim (dec_claim),
        .dec_io    (dec_io),
        .dec_win   (dec_win),
        .dec_addr  (dec_addr)
    );

    function automatic logic exp_claim(logic [31:0] a, logic io, logic [31:0] en);
        if (io) return 1'b1;
        return (a[31:28] == 4'hF) && en[a[27:23]];
    endfunction

    function automatic logic [4:0] exp_win(logic [31:0] a, logic io, logic [31:0] en);
        if (!io && exp_claim(a, io, en)) return a[27:23];
        return 5'd0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request, optional same-cycle bitmap write; checks the decode
    task automatic send(logic [31:0] a, logic io, logic wr, logic [3:0] wofs,
                        logic [31:0] wd, string req);
        logic [31:0] en_old;
        en_old    = model_en;
        req_valid = 1'b1;
        req_addr  = a;
        req_io    = io;
        cfg_wr    = wr;
        cfg_addr  = wofs;
        cfg_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr    = 1'b0;
        chk(req, {31'd0, dec_valid}, 32'd1);
        chk(req, {31'd0, dec_claim}, {31'd0, exp_claim(a, io, en_old)});
        chk(req, {31'd0, dec_io}, {31'd0, io});
        chk(req, {27'd0, dec_win}, {27'd0, exp_win(a, io, en_old)});
        chk(req, dec_addr, a);
        if (wr && wofs == OFS) model_en = wd;
    endtask

    task automatic write_en(logic [3:0] ofs, logic [31:0] wd);
        cfg_wr    = 1'b1;
        cfg_addr  = ofs;
        cfg_wdata = wd;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (ofs == OFS) model_en = wd;
    endtask

    task automatic read_chk(logic [3:0] ofs, string req);
        cfg_rd   = 1'b1;
        cfg_addr = ofs;
        @(negedge clk);
        cfg_rd = 1'b0;
        chk(req, cfg_rdata, (ofs == OFS) ? model_en : 32'd0);
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk("R10", {29'd0, dec_valid, dec_claim, dec_io}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [31:0] a;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1", {31'd0, dec_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk(OFS, "R1");
        send(32'hF000_0000, 1'b0, 1'b0, OFS, 32'd0, "R1");
        send(32'hFFFF_FFFF, 1'b0, 1'b0, OFS, 32'd0, "R1");
        idle_chk();

        // I/O space unaffected by an empty bitmap
        send(32'h0000_1234, 1'b1, 1'b0, OFS, 32'd0, "R7");
        send(32'hF080_0000, 1'b1, 1'b0, OFS, 32'd0, "R7");

        // same-cycle write uses the old bitmap, next request the new one
        send(32'hF080_0000, 1'b0, 1'b1, OFS, 32'hFFFF_FFFF, "R9");
        send(32'hF080_0000, 1'b0, 1'b0, OFS, 32'd0, "R9");
        read_chk(OFS, "R8");

        // outside the top region stays unclaimed
        send(32'hEFFF_FFFF, 1'b0, 1'b0, OFS, 32'd0, "R3");
        send(32'h7000_0000, 1'b0, 1'b0, OFS, 32'd0, "R3");
        send(32'hFFFF_FFFF, 1'b0, 1'b0, OFS, 32'd0, "R2");

        // adjacent slices 5 and 6 form one range; 4 and 7 stay out
        write_en(OFS, 32'h0000_0060);
        send(32'hF2FF_FFFF, 1'b0, 1'b0, OFS, 32'd0, "R6");
        send(32'hF300_0000, 1'b0, 1'b0, OFS, 32'd0, "R6");
        send(32'hF27F_FFFF, 1'b0, 1'b0, OFS, 32'd0, "R5");
        send(32'hF380_0000, 1'b0, 1'b0, OFS, 32'd0, "R5");

        // other offsets: write ignored, read returns zero
        write_en(4'd0, 32'hFFFF_FFFF);
        read_chk(OFS, "R8");
        read_chk(4'd0, "R8");
        read_chk(4'd15, "R8");
        send(32'hF000_0000, 1'b0, 1'b0, OFS, 32'd0, "R8");

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            int unsigned pick;
            logic        io;
            logic        wr;
            pick = $urandom_range(0, 99);
            a    = $urandom();
            if (pick < 75) a[31:28] = 4'hF;
            io = ($urandom_range(0, 9) == 0);
            wr = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 19) == 0) begin
                idle_chk();
            end else if ($urandom_range(0, 19) == 0) begin
                read_chk(($urandom_range(0, 3) == 0) ? 4'd2 : OFS, "R8");
            end else begin
                send(a, io, wr, ($urandom_range(0, 5) == 0) ? 4'd1 : OFS,
                     $urandom(), io ? "R7" : "R2");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule